// File: doc/BRIEF.md
# GPIO Edge-Interrupt Controller

A 32-bit general-purpose I/O controller with a small word-addressed register file. Software sets each pin's direction and output level. It reads back the levels on the input pins. It arms a per-pin interrupt that fires on a rising edge, a falling edge, or both.

Inputs cross into the clock domain through a two-stage synchronizer. Each detected edge is qualified by the pin's select bits, its interrupt mask and its input direction. A qualified edge sets a sticky status bit. The single `irq` line is the OR of the status bits whose mask is set.

Status bits are cleared only through a dedicated write-one-to-clear register. The register port has no back-pressure: every request is accepted in the cycle it is presented. It is answered one cycle later with `ack` and, for reads, `rdata`.

Register map (word index on `addr`):

| Index | Register | Access |
|---|---|---|
| 0 | direction (1 = output) | read/write |
| 1 | output data | read/write |
| 2 | input levels | read only |
| 3 | interrupt mask | read/write |
| 4 | rising-edge select | read/write |
| 5 | falling-edge select | read/write |
| 6 | status clear | write only, reads 0 |
| 7 | status | read only |

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: A write to index 0 drives `pin_oe`, and a write to index 1 drives `pin_out`, bit for bit, from the cycle after the write.
- R3: Reading index 2 returns the synchronized pin levels for pins whose direction bit is 0, and 0 for output pins. A pin change is visible there from the third clock edge after it occurs.
- R4: With rising select, mask and input direction set for a bit, a 0-to-1 transition sets that status bit on the third clock edge after the pin changes. The bit stays set after the pin returns low.
- R5: With falling select, mask and input direction set for a bit, a 1-to-0 transition sets that status bit. Pulsing all-ones pins to a value and back leaves the status equal to the complement of that value.
- R6: With both selects set for a bit, either transition sets the status bit.
- R7: An edge on a bit whose mask bit is 0, or whose direction bit is 1, leaves the status bit unchanged.
- R8: Writing 1 to a bit of index 6 clears that status bit, and writing 0 leaves it unchanged. Writes to index 2 and index 7 have no effect.
- R9: When a qualified edge and a clear of the same bit meet in one cycle, the status bit ends set.
- R10: `irq` is 1 exactly when some status bit is set and its mask bit is 1. It returns to 0 once status is cleared.
- R11: Each request gives an `ack` pulse one cycle later. A read gives `rdata` in that same cycle, and index 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `ack` |
| ack | output | 1 | Acknowledge, one cycle after `req` |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
Directed alternating patterns (0x55/0xAA and 0x5A/0xA5 style words) show that output and input bits keep their positions and do not swap neighbours. Pulses from all-zeros and from all-ones separate rising from falling detection, and the complement result of the falling case exposes any inversion. Split masks, split selects and split direction words check that the gating works on each bit separately. A clear landed in the exact cycle of an edge checks the set-over-clear priority. A seeded random mix of register writes, pin changes and read-backs, compared against a bench model, then covers the interplay of mask, select, direction and clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_IN   = 3'd2,
    REG_MASK = 3'd3,
    REG_RISE = 3'd4,
    REG_FALL = 3'd5,
    REG_CLR  = 3'd6,
    REG_STAT = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_sel_i,
  input  logic [W-1:0] fall_sel_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] in_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] status_q;
  logic [W-1:0] rise_ev, fall_ev, set_ev;

  assign rise_ev = lvl_i & ~prev_q;
  assign fall_ev = ~lvl_i & prev_q;
  assign set_ev  = ((rise_ev & rise_sel_i) | (fall_ev & fall_sel_i)) & mask_i & in_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl_i;
      status_q <= (status_q & ~clr_i) | set_ev;
    end
  end

  assign status_o = status_q;

  // R4 / R7: a status bit rises only after a qualified edge
  a_r4_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & ~$past(set_ev)) == '0);

  // R8: a cleared bit without a competing edge reads 0
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & $past(clr_i & ~set_ev)) == '0);

  // R9: an edge always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (~status_q & $past(set_ev)) == '0);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              ack,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  logic [W-1:0] dir_q, out_q, mask_q, rise_q, fall_q;
  logic [W-1:0] lvl_sync, status, clr_vec, in_view;
  logic [W-1:0] rdata_q;
  logic         ack_q;
  logic         wr;

  assign wr      = req & we;
  assign clr_vec = (wr && addr == REG_CLR) ? wdata : '0;
  assign in_view = lvl_sync & ~dir_q;

  gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (lvl_sync)
  );

  gpio_edge_status #(.W(W)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl_sync),
    .rise_sel_i (rise_q),
    .fall_sel_i (fall_q),
    .mask_i     (mask_q),
    .in_en_i    (~dir_q),
    .clr_i      (clr_vec),
    .status_o   (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr) begin
      case (addr)
        REG_DIR:  dir_q  <= wdata;
        REG_OUT:  out_q  <= wdata;
        REG_MASK: mask_q <= wdata;
        REG_RISE: rise_q <= wdata;
        REG_FALL: fall_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= req;
      if (req && !we) begin
        case (addr)
          REG_DIR:  rdata_q <= dir_q;
          REG_OUT:  rdata_q <= out_q;
          REG_IN:   rdata_q <= in_view;
          REG_MASK: rdata_q <= mask_q;
          REG_RISE: rdata_q <= rise_q;
          REG_FALL: rdata_q <= fall_q;
          REG_STAT: rdata_q <= status;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata   = rdata_q;
  assign ack     = ack_q;
  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq     = |(status & mask_q);

  // R11: every request is acknowledged on the next cycle
  a_r11_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);

  // R11: no acknowledge without a request
  a_r11_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));

  // R2: direction write reaches the output enables
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == REG_DIR) |=> pin_oe == $past(wdata));

  // R10: no interrupt while status is empty
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic        ack, irq;

  int checks = 0, errors = 0;

  // bench model
  logic [31:0] m_dir = '0, m_out = '0, m_mask = '0, m_rise = '0, m_fall = '0, m_st = '0, m_pins = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] edge_events(input logic [31:0] o, input logic [31:0] n);
    return m_mask & ~m_dir & ((~o & n & m_rise) | (o & ~n & m_fall));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    case (a)
      3'd0: m_dir  = d;
      3'd1: m_out  = d;
      3'd3: m_mask = d;
      3'd4: m_rise = d;
      3'd5: m_fall = d;
      3'd6: m_st   = m_st & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    check("R11 ack", {31'b0, ack}, 32'd1);
    d = rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    logic [31:0] ev;
    ev = edge_events(m_pins, v);
    pin_in = v;
    repeat (4) @(negedge clk);
    m_st = m_st | ev;
    m_pins = v;
  endtask

  task automatic check_stat(input string tag);
    logic [31:0] d;
    rd(3'd7, d);
    check(tag, d, m_st);
    check("R10 irq", {31'b0, irq}, {31'b0, |(m_st & m_mask)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R11 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      check("R1 reset reg", d, 32'h0);
    end
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2: outputs
    wr(3'd0, 32'hFFFF_FFFF);
    check("R2 pin_oe", pin_oe, 32'hFFFF_FFFF);
    wr(3'd1, 32'h5555_5555);
    check("R2 pin_out 55", pin_out, 32'h5555_5555);
    wr(3'd1, 32'hAAAA_AAAA);
    check("R2 pin_out AA", pin_out, 32'hAAAA_AAAA);
    rd(3'd1, d);
    check("R2 out readback", d, 32'hAAAA_AAAA);

    // R3: input levels, masked by direction
    wr(3'd0, 32'h0);
    set_pins(32'h5A5A_5A5A);
    rd(3'd2, d);
    check("R3 input all", d, 32'h5A5A_5A5A);
    wr(3'd0, 32'h0000_FFFF);
    rd(3'd2, d);
    check("R3 input split dir", d, 32'h5A5A_0000);
    wr(3'd0, 32'h0);

    // R4: rising edges, sticky
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'h0);
    set_pins(32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    set_pins(32'hA5A5_A5A5);
    set_pins(32'h0);
    check_stat("R4 rising sticky");
    check("R4 rising literal", m_st, 32'hA5A5_A5A5);

    // R8: partial clear, read-only writes ignored
    wr(3'd6, 32'h0000_FFFF);
    check_stat("R8 partial clear");
    req = 1'b1; we = 1'b1; addr = 3'd7; wdata = 32'hFFFF_FFFF;
    @(negedge clk); req = 1'b0; we = 1'b0;
    req = 1'b1; we = 1'b1; addr = 3'd2; wdata = 32'hFFFF_FFFF;
    @(negedge clk); req = 1'b0; we = 1'b0;
    check_stat("R8 status write ignored");
    rd(3'd2, d);
    check("R8 input write ignored", d, 32'h0);
    rd(3'd6, d);
    check("R11 clear reads zero", d, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    check_stat("R8 full clear");
    check("R10 irq dropped", {31'b0, irq}, 32'h0);

    // R5: falling edges give the complement
    wr(3'd4, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    set_pins(32'hFFFF_FFFF);
    set_pins(32'h3C3C_1234);
    set_pins(32'hFFFF_FFFF);
    check_stat("R5 falling");
    check("R5 complement", m_st, ~32'h3C3C_1234);
    wr(3'd6, 32'hFFFF_FFFF);

    // R6: both edges on selected bits
    wr(3'd4, 32'h0F0F_0F0F);
    wr(3'd5, 32'h0F0F_0F0F);
    set_pins(32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    set_pins(32'h0000_FFFF);
    check_stat("R6 both rise");
    wr(3'd6, 32'hFFFF_FFFF);
    set_pins(32'h0);
    check_stat("R6 both fall");
    check("R6 literal", m_st, 32'h0000_0F0F);
    wr(3'd6, 32'hFFFF_FFFF);

    // R7: mask and direction gating
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0000_FFFF);
    wr(3'd0, 32'h0000_00FF);
    set_pins(32'hFFFF_FFFF);
    check_stat("R7 gated");
    check("R7 literal", m_st, 32'h0000_FF00);
    set_pins(32'h0);
    wr(3'd0, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);

    // R9: clear lands in the cycle of an edge
    wr(3'd3, 32'hFFFF_FFFF);
    pin_in = 32'h0000_0001;
    @(negedge clk); @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 3'd6; wdata = 32'h0000_0001;
    @(negedge clk); req = 1'b0; we = 1'b0;
    @(negedge clk);
    m_pins = 32'h0000_0001;
    m_st = 32'h0000_0001;
    check_stat("R9 set wins");
    wr(3'd6, 32'hFFFF_FFFF);

    // random mix
    for (int it = 0; it < 80; it++) begin
      case ($urandom % 5)
        0: wr(3'($urandom % 8), $urandom);
        1, 2: set_pins($urandom);
        3: begin
          v = $urandom;
          wr(3'd6, v);
        end
        default: begin
          rd(3'd2, d);
          check("R3 random input", d, m_pins & ~m_dir);
        end
      endcase
      check_stat("R4 random status");
      check("R2 random pin_out", pin_out, m_out);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule